// File: doc/BRIEF.md
# E1 Signaling-Channel Alarm Detector

This block watches the signaling octet that an E1 framer extracts from channel 16 of every frame. It reports two signaling-channel alarms. One is a channel that stayed entirely at zero for a whole 16-frame multiframe. The other is a channel that is practically all ones: fewer than three zero bits among the 128 bits carried by 16 consecutive frames. Each alarm appears as a one-clock event pulse. A sticky status register in the surrounding framer captures these pulses.

The framer supplies the following inputs:

- the octet, together with a strobe that marks each new frame;
- a marker that flags the first frame of a multiframe;
- a mode bit that selects E1 operation.

The detector aligns its 16-frame window to the marker. After a window completes, the detector keeps running, so the next window starts with the following frame. A new marker always realigns the window and throws away any partial window. In T1 operation both detectors stay idle and alignment is lost. The all-ones detector has no dependence on the signaling type, so it keeps running when the channel carries common-channel signaling.

Top module: `ts16_sig_alarm`

## Requirements
- R1: After synchronous reset both event outputs are low and the window is unaligned. No event occurs, whatever octets arrive, until a frame strobe arrives together with the multiframe marker.
- R2: The marker is accepted only in a cycle where `frame_vld` is high. That frame becomes frame 0 of a new window. A marker given while `frame_vld` is low has no effect.
- R3: `zero_evt` pulses for exactly one cycle, the cycle after the clock edge that accepts frame 15 of a window. It pulses only if every octet of frames 0 to 15 was 8'h00.
- R4: `ones_evt` pulses for one cycle at the same point as `zero_evt`. It pulses only if the total number of zero bits across the 16 octets of the window is below three.
- R5: The zero-bit count saturates at three. A window holding exactly two zero bits raises `ones_evt`. A window holding three or more zero bits, however many, raises neither event.
- R6: A marker that arrives inside a window restarts the count at frame 0. The partial window gives no event, and the next event falls 16 frames after the new marker.
- R7: After a window completes, the next frame begins a new window with no marker needed. Two multiframes of zero octets therefore give two `zero_evt` pulses.
- R8: While `e1_mode` is low, no event is raised and alignment is dropped. After a return to E1 mode, frames without a marker raise no event.
- R9: `zero_evt` and `ones_evt` are never high in the same cycle, and neither is high in two consecutive cycles.
- R10: Cycles with `frame_vld` low do not advance the window, and their `ts16_octet` value does not change the counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| e1_mode | input | 1 | 1 = E1 operation, 0 = T1 operation (detectors idle) |
| frame_vld | input | 1 | One-cycle strobe; `ts16_octet` holds a new frame's signaling octet |
| mf_start | input | 1 | Marks the strobed frame as the first of a multiframe |
| ts16_octet | input | 8 | Channel-16 signaling octet |
| zero_evt | output | 1 | One-cycle pulse: whole multiframe carried zeros only |
| ones_evt | output | 1 | One-cycle pulse: fewer than three zero bits in 16 frames |

## Verification
The bench builds the block with its default parameters: 16 frames per window, 8-bit octets, and a zero limit of three. With these values the saturation point of the 2-bit counter is reachable with just a few hand-placed zero bits. The two-versus-three boundary of the all-ones alarm is therefore probed directly, next to octets that hold many zeros at once. A window of 16 frames keeps the restart, freewheel and mode-change scenarios short enough to run each several times against the behavioural model on every clock.

// File: rtl/ts16_alarm_pkg.sv
package ts16_alarm_pkg;

    localparam int DEF_FRAMES     = 16;
    localparam int DEF_OCTET_BITS = 8;
    localparam int DEF_ZERO_LIMIT = 3;

    typedef enum logic {
        WIN_UNALIGNED = 1'b0,
        WIN_TRACKING  = 1'b1
    } win_state_e;

    typedef struct packed {
        logic take;   // frame accepted into the current window
        logic first;  // accepted frame is frame 0 of the window
        logic last;   // accepted frame closes the window
    } win_ctl_t;

    function automatic int unsigned sat_sum(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned cap);
        int unsigned s;
        s = a + b;
        return (s > cap) ? cap : s;
    endfunction

endpackage

// File: rtl/ts16_frame_window.sv
module ts16_frame_window
    import ts16_alarm_pkg::*;
#(
    parameter int FRAMES = DEF_FRAMES
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     e1_mode,
    input  logic     frame_vld,
    input  logic     mf_start,
    output win_ctl_t ctl
);
    localparam int IDX_W = (FRAMES > 1) ? $clog2(FRAMES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAMES - 1);

    win_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] eff_idx;

    always_comb begin
        eff_idx   = mf_start ? '0 : idx_q;
        ctl.take  = frame_vld && e1_mode && (mf_start || state_q == WIN_TRACKING);
        ctl.first = (eff_idx == '0);
        ctl.last  = (eff_idx == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst || !e1_mode) begin
            state_q <= WIN_UNALIGNED;
            idx_q   <= '0;
        end else if (ctl.take) begin
            state_q <= WIN_TRACKING;
            idx_q   <= ctl.last ? '0 : IDX_W'(eff_idx + 1'b1);
        end
    end

endmodule

// File: rtl/ts16_zero_tally.sv
module ts16_zero_tally
    import ts16_alarm_pkg::*;
#(
    parameter int OCTET_BITS = DEF_OCTET_BITS,
    parameter int ZERO_LIMIT = DEF_ZERO_LIMIT,
    localparam int CNT_W     = $clog2(ZERO_LIMIT + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  win_ctl_t              ctl,
    input  logic [OCTET_BITS-1:0] octet,
    output logic [CNT_W-1:0]      win_zeros,
    output logic                  win_any_one
);
    logic [CNT_W-1:0] acc_q;
    logic             any_one_q;
    int unsigned      octet_zeros;
    int unsigned      base;

    always_comb begin
        octet_zeros = 0;
        for (int i = 0; i < OCTET_BITS; i++) begin
            if (!octet[i]) octet_zeros = octet_zeros + 1;
        end
        base        = ctl.first ? 0 : int'(acc_q);
        win_zeros   = CNT_W'(sat_sum(base, octet_zeros, ZERO_LIMIT));
        win_any_one = (!ctl.first && any_one_q) || (|octet);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            any_one_q <= 1'b0;
        end else if (ctl.take) begin
            acc_q     <= win_zeros;
            any_one_q <= win_any_one;
        end
    end

endmodule

// File: rtl/ts16_sig_alarm.sv
module ts16_sig_alarm
    import ts16_alarm_pkg::*;
#(
    parameter int FRAMES_PER_MF   = DEF_FRAMES,
    parameter int OCTET_BITS      = DEF_OCTET_BITS,
    parameter int ONES_ZERO_LIMIT = DEF_ZERO_LIMIT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  e1_mode,
    input  logic                  frame_vld,
    input  logic                  mf_start,
    input  logic [OCTET_BITS-1:0] ts16_octet,
    output logic                  zero_evt,
    output logic                  ones_evt
);
    localparam int CNT_W = $clog2(ONES_ZERO_LIMIT + 1);

    win_ctl_t         ctl;
    logic [CNT_W-1:0] win_zeros;
    logic             win_any_one;

    ts16_frame_window #(.FRAMES(FRAMES_PER_MF)) u_win (
        .clk       (clk),
        .rst       (rst),
        .e1_mode   (e1_mode),
        .frame_vld (frame_vld),
        .mf_start  (mf_start),
        .ctl       (ctl)
    );

    ts16_zero_tally #(
        .OCTET_BITS (OCTET_BITS),
        .ZERO_LIMIT (ONES_ZERO_LIMIT)
    ) u_tally (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .octet       (ts16_octet),
        .win_zeros   (win_zeros),
        .win_any_one (win_any_one)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_evt <= 1'b0;
            ones_evt <= 1'b0;
        end else begin
            zero_evt <= ctl.take && ctl.last && !win_any_one;
            ones_evt <= ctl.take && ctl.last &&
                        (win_zeros < CNT_W'(ONES_ZERO_LIMIT));
        end
    end

endmodule

// File: rtl/ts16_sig_alarm_chk.sv
module ts16_sig_alarm_chk (
    input logic clk,
    input logic rst,
    input logic e1_mode,
    input logic frame_vld,
    input logic zero_evt,
    input logic ones_evt
);
    p_t1_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !e1_mode |=> (!zero_evt && !ones_evt));

    p_zero_single_r9: assert property (@(posedge clk) disable iff (rst)
        zero_evt |=> !zero_evt);

    p_ones_single_r9: assert property (@(posedge clk) disable iff (rst)
        ones_evt |=> !ones_evt);

    p_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        zero_evt |-> !ones_evt);

    p_from_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        (zero_evt || ones_evt) |-> $past(frame_vld));

    p_from_e1_r8: assert property (@(posedge clk) disable iff (rst)
        (zero_evt || ones_evt) |-> $past(e1_mode));
endmodule

bind ts16_sig_alarm ts16_sig_alarm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .e1_mode   (e1_mode),
    .frame_vld (frame_vld),
    .zero_evt  (zero_evt),
    .ones_evt  (ones_evt)
);

// File: tb/sim_ts16_sig_alarm.sv
module sim_ts16_sig_alarm;
    localparam int NFR   = 16;
    localparam int LIMIT = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       e1_mode = 1'b1;
    logic       frame_vld = 1'b0;
    logic       mf_start = 1'b0;
    logic [7:0] ts16_octet = 8'h00;
    logic       zero_evt;
    logic       ones_evt;

    int checks = 0;
    int errors = 0;
    int n_zero = 0;
    int n_ones = 0;
    int n_coinc = 0;
    int n_double = 0;
    bit done = 0;
    logic [7:0] idle_oct = 8'h00;

    // reference model state
    bit m_al = 0;
    int m_idx = 0;
    int m_zs = 0;
    bit m_one = 0;
    bit ez = 0;
    bit eo = 0;
    bit prev_z = 0;
    bit prev_o = 0;

    always #5 clk = ~clk;

    ts16_sig_alarm u0 (
        .clk(clk), .rst(rst), .e1_mode(e1_mode), .frame_vld(frame_vld),
        .mf_start(mf_start), .ts16_octet(ts16_octet),
        .zero_evt(zero_evt), .ones_evt(ones_evt)
    );

    function automatic int zeros_in(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) if (v[i] == 1'b0) n++;
        return n;
    endfunction

    always begin
        @(posedge clk);
        if (rst) begin
            m_al = 0; m_idx = 0; m_zs = 0; m_one = 0; ez = 0; eo = 0;
        end else begin
            ez = 0; eo = 0;
            if (!e1_mode) begin
                m_al = 0; m_idx = 0;
            end else if (frame_vld && (mf_start || m_al)) begin
                if (mf_start) begin m_idx = 0; m_zs = 0; m_one = 0; end
                m_zs += zeros_in(ts16_octet);
                if (ts16_octet != 8'h00) m_one = 1;
                m_al = 1;
                if (m_idx == NFR - 1) begin
                    ez = !m_one;
                    eo = (m_zs < LIMIT);
                    m_idx = 0; m_zs = 0; m_one = 0;
                end else begin
                    m_idx++;
                end
            end
        end
        #1;
        checks++;
        if (zero_evt !== ez) begin
            errors++;
            $display("FAIL R3 zero_evt actual=%b expected=%b t=%0t", zero_evt, ez, $time);
        end
        checks++;
        if (ones_evt !== eo) begin
            errors++;
            $display("FAIL R4 ones_evt actual=%b expected=%b t=%0t", ones_evt, eo, $time);
        end
        if (zero_evt === 1'b1) n_zero++;
        if (ones_evt === 1'b1) n_ones++;
        if (zero_evt === 1'b1 && ones_evt === 1'b1) n_coinc++;
        if ((zero_evt === 1'b1 && prev_z) || (ones_evt === 1'b1 && prev_o)) n_double++;
        prev_z = (zero_evt === 1'b1);
        prev_o = (ones_evt === 1'b1);
    end

    task automatic frame(input logic [7:0] oct, input bit mk);
        @(negedge clk);
        frame_vld = 1'b1; mf_start = mk; ts16_octet = oct;
        @(negedge clk);
        frame_vld = 1'b0; mf_start = 1'b0; ts16_octet = idle_oct;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one window: marker on frame 0, octet list supplied by position
    task automatic window_ff_with(input int p1, input logic [7:0] v1,
                                  input int p2, input logic [7:0] v2);
        for (int f = 0; f < NFR; f++) begin
            logic [7:0] o;
            o = 8'hFF;
            if (f == p1) o = v1;
            if (f == p2) o = v2;
            frame(o, f == 0);
        end
        idle(2);
    endtask

    initial begin
        int z0, o0;
        idle(3);
        @(negedge clk);
        check_int("R1 reset zero_evt", int'(zero_evt), 0);
        check_int("R1 reset ones_evt", int'(ones_evt), 0);
        rst = 1'b0;

        // R1: no marker yet, zero octets give no event
        z0 = n_zero; o0 = n_ones;
        for (int f = 0; f < 20; f++) frame(8'h00, 0);
        idle(2);
        check_int("R1 unaligned zero pulses", n_zero - z0, 0);
        check_int("R1 unaligned ones pulses", n_ones - o0, 0);

        // R3: full multiframe of zeros
        z0 = n_zero; o0 = n_ones;
        for (int f = 0; f < NFR; f++) frame(8'h00, f == 0);
        idle(2);
        check_int("R3 all-zero window pulses", n_zero - z0, 1);
        check_int("R3 all-zero ones pulses", n_ones - o0, 0);

        // R4: all ones
        z0 = n_zero; o0 = n_ones;
        window_ff_with(-1, 8'hFF, -1, 8'hFF);
        check_int("R4 all-ones pulses", n_ones - o0, 1);
        check_int("R4 all-ones zero pulses", n_zero - z0, 0);

        // R5: exactly two zero bits -> event
        o0 = n_ones;
        window_ff_with(5, 8'hFE, 9, 8'h7F);
        check_int("R5 two zeros pulses", n_ones - o0, 1);
        // R5: three zero bits -> none
        o0 = n_ones;
        window_ff_with(2, 8'hFC, 14, 8'hEF);
        check_int("R5 three zeros pulses", n_ones - o0, 0);
        // R5: many zeros in one octet (saturation) -> none
        z0 = n_zero; o0 = n_ones;
        window_ff_with(0, 8'h00, 15, 8'h00);
        check_int("R5 saturated ones pulses", n_ones - o0, 0);
        check_int("R5 saturated zero pulses", n_zero - z0, 0);

        // R6: marker mid-window restarts
        o0 = n_ones;
        for (int f = 0; f < 8; f++) frame(8'hFF, f == 0);
        for (int f = 0; f < NFR; f++) frame(8'hFF, f == 0);
        idle(2);
        check_int("R6 restart ones pulses", n_ones - o0, 1);

        // R7: freewheel into second window
        z0 = n_zero;
        for (int f = 0; f < 2 * NFR; f++) frame(8'h00, f == 0);
        idle(2);
        check_int("R7 freewheel zero pulses", n_zero - z0, 2);

        // R10: idle cycles carry zero octets, must not matter
        o0 = n_ones;
        idle_oct = 8'h00;
        for (int f = 0; f < NFR; f++) begin
            frame(8'hFF, f == 0);
            idle(1);
        end
        idle(2);
        check_int("R10 idle octets ignored pulses", n_ones - o0, 1);

        // R8: T1 mode suppresses everything
        z0 = n_zero; o0 = n_ones;
        @(negedge clk); e1_mode = 1'b0;
        for (int f = 0; f < NFR; f++) frame(8'h00, f == 0);
        window_ff_with(-1, 8'hFF, -1, 8'hFF);
        @(negedge clk); e1_mode = 1'b1;
        for (int f = 0; f < NFR; f++) frame(8'h00, 0);
        idle(2);
        check_int("R8 T1 zero pulses", n_zero - z0, 0);
        check_int("R8 T1 ones pulses", n_ones - o0, 0);

        // R2: marker without strobe ignored
        z0 = n_zero;
        @(negedge clk); mf_start = 1'b1;
        @(negedge clk); mf_start = 1'b0;
        for (int f = 0; f < NFR; f++) frame(8'h00, 0);
        idle(2);
        check_int("R2 strobeless marker pulses", n_zero - z0, 0);
        // R2: marker with strobe realigns
        for (int f = 0; f < NFR; f++) frame(8'h00, f == 0);
        idle(2);
        check_int("R2 strobed marker pulses", n_zero - z0, 1);

        // R9: exclusivity and single-cycle width over the whole run
        check_int("R9 coincident pulses", n_coinc, 0);
        check_int("R9 back-to-back pulses", n_double, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule